// File: doc/BRIEF.md
# Peripheral Interrupt Register Bank

This block keeps the interrupt bookkeeping of one peripheral: for every interrupt source it holds a latched state bit, an enable bit and a write-only test bit. It drives one active-high level interrupt line per source. The peripheral's own logic presents a vector of cause signals. Software reaches the three registers through a simple word port made of an address, a write strobe, write data and combinational read data.

A parameter marks each source as either event type or status type. An event-type source latches its cause until software clears it by writing a 1. A status-type source mirrors its cause with one cycle of delay, so a clear write cannot outlast the cause. The value read from the state register is always raw. The enable only gates the output lines.

Top module: `irq_bank`

## Requirements
- R1: After the active-low asynchronous reset, every state bit, every enable bit and every interrupt output is 0, and reads of all three registers return 0.
- R2: The state register is at byte offset 0x0, the enable register at 0x4 and the test register at 0x8. Bit i of each register belongs to source i.
- R3: NUM_SRC must lie between 1 and 32, and any other value stops elaboration. Register bits at and above NUM_SRC read as 0, and writing them has no effect.
- R4: The enable register can be read and written. A 1 in bit i lets source i reach irq_o[i].
- R5: When the cause of a source is high at a clock edge, its state bit reads 1 after that edge. For an event-type source the bit stays 1 after the cause drops.
- R6: For an event-type source, writing 1 to its bit at offset 0x0 clears the state bit at the next edge. Writing 0 leaves the bit unchanged, and the bit is never cleared by hardware.
- R7: If the cause of an event-type source is high in the same cycle as a clear write to its bit, the state bit stays 1, because setting takes priority over clearing.
- R8: Writing 1 to bit i at offset 0x8 sets state bit i exactly as a cause would. The test register always reads 0, and the write does not change the enable register.
- R9: A state read returns the latched bits without masking by enable. irq_o[i] equals state bit i AND enable bit i, with no delay added after the state register.
- R10: For a status-type source, the state bit equals the cause sampled at the previous edge. A clear write has no lasting effect while the cause is high, and the bit falls one cycle after the cause falls.
- R11: A read at any offset other than 0x0, 0x4 or 0x8 returns 0. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cause_i | input | NUM_SRC | Per-source interrupt cause from the peripheral logic |
| reg_addr_i | input | ADDR_W | Byte address of the register access |
| reg_we_i | input | 1 | Write strobe, one write per cycle it is high |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| irq_o | output | NUM_SRC | Active-high level interrupt per source |

## Verification
Assertions inside each per-source cell check the following on every cycle:
- a cause or test write sets the state bit at the next edge;
- a lone clear empties an event-type bit, and without a clear that bit holds;
- a status-type bit falls when neither cause nor test is present;
- an enable write lands in the enable bit.

Only the bench's scenarios can show the rest. That covers the address map and unmapped offsets, the zero read of the test register, the masking of bits above NUM_SRC, and the priority of a cause over a simultaneous clear. It also covers the raw state read against the masked output. A behavioural model compares both outputs on every cycle.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int unsigned OFF_STATE  = 0;
    localparam int unsigned OFF_ENABLE = 4;
    localparam int unsigned OFF_TEST   = 8;
    localparam int unsigned REG_W      = 32;
    localparam int unsigned MAX_SRC    = 32;

    typedef struct packed {
        logic state;
        logic en;
    } src_cell_t;

endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode #(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned ADDR_W  = 4
) (
    input  logic [ADDR_W-1:0]                 addr_i,
    input  logic                              we_i,
    input  logic [irq_bank_pkg::REG_W-1:0]    wdata_i,
    input  logic [NUM_SRC-1:0]                state_i,
    input  logic [NUM_SRC-1:0]                en_i,
    output logic [NUM_SRC-1:0]                clr_o,
    output logic [NUM_SRC-1:0]                tst_o,
    output logic                              en_we_o,
    output logic [irq_bank_pkg::REG_W-1:0]    rdata_o
);
    import irq_bank_pkg::*;

    logic hit_state, hit_en, hit_test;

    always_comb begin
        hit_state = (addr_i == ADDR_W'(OFF_STATE));
        hit_en    = (addr_i == ADDR_W'(OFF_ENABLE));
        hit_test  = (addr_i == ADDR_W'(OFF_TEST));

        clr_o   = (we_i && hit_state) ? wdata_i[NUM_SRC-1:0] : '0;
        tst_o   = (we_i && hit_test)  ? wdata_i[NUM_SRC-1:0] : '0;
        en_we_o = we_i && hit_en;

        // R11: unmapped offsets read as zero; R8: test register reads zero
        rdata_o = '0;
        if (hit_state) begin
            rdata_o[NUM_SRC-1:0] = state_i;
        end else if (hit_en) begin
            rdata_o[NUM_SRC-1:0] = en_i;
        end
    end

endmodule

// File: rtl/irq_bank_cell.sv
module irq_bank_cell #(
    parameter bit IS_STATUS = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cause_i,
    input  logic clr_i,
    input  logic tst_i,
    input  logic en_we_i,
    input  logic en_wd_i,
    output logic state_o,
    output logic en_o,
    output logic irq_o
);
    import irq_bank_pkg::*;

    src_cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (IS_STATUS) begin
            cell_d.state = cause_i | tst_i;
        end else begin
            // set wins over clear (R7)
            cell_d.state = (cell_q.state & ~clr_i) | cause_i | tst_i;
        end
        if (en_we_i) begin
            cell_d.en = en_wd_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    assign state_o = cell_q.state;
    assign en_o    = cell_q.en;
    assign irq_o   = cell_q.state & cell_q.en;

    p_cause_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cause_i |=> cell_q.state);

    p_test_sets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tst_i |=> cell_q.state);

    p_en_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_we_i |=> (cell_q.en == $past(en_wd_i)));

    if (IS_STATUS) begin : g_status
        p_follow_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!cause_i && !tst_i) |=> !cell_q.state);
    end else begin : g_event
        p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i && !cause_i && !tst_i) |=> !cell_q.state);
        p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (cell_q.state && !clr_i) |=> cell_q.state);
    end

endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
    parameter int unsigned NUM_SRC     = 8,
    parameter int unsigned ADDR_W      = 4,
    parameter logic [31:0] STATUS_MASK = 32'h0000_00C0
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NUM_SRC-1:0]   cause_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic                 reg_we_i,
    input  logic [31:0]          reg_wdata_i,
    output logic [31:0]          reg_rdata_o,
    output logic [NUM_SRC-1:0]   irq_o
);
    import irq_bank_pkg::*;

    // R3: source count limited to the register width
    if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_count
        $error("irq_bank: NUM_SRC out of range 1..32");
    end
    if (ADDR_W < 4) begin : g_bad_addr
        $error("irq_bank: ADDR_W too small for the register map");
    end

    logic [NUM_SRC-1:0] state_w, en_w, clr_w, tst_w;
    logic               en_we_w;

    irq_bank_decode #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W)
    ) u_decode (
        .addr_i  (reg_addr_i),
        .we_i    (reg_we_i),
        .wdata_i (reg_wdata_i),
        .state_i (state_w),
        .en_i    (en_w),
        .clr_o   (clr_w),
        .tst_o   (tst_w),
        .en_we_o (en_we_w),
        .rdata_o (reg_rdata_o)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        irq_bank_cell #(
            .IS_STATUS (STATUS_MASK[i])
        ) u_cell (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .cause_i (cause_i[i]),
            .clr_i   (clr_w[i]),
            .tst_i   (tst_w[i]),
            .en_we_i (en_we_w),
            .en_wd_i (reg_wdata_i[i]),
            .state_o (state_w[i]),
            .en_o    (en_w[i]),
            .irq_o   (irq_o[i])
        );
    end

endmodule

// File: tb/irq_bank_tb.sv
module irq_bank_tb;

    localparam int N = 8;
    localparam logic [31:0] SMASK = 32'h0000_00C0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  cause = '0;
    logic [3:0]    addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [N-1:0]  irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    logic [N-1:0] m_state = '0;
    logic [N-1:0] m_en = '0;

    always #2 clk = ~clk;

    irq_bank #(.NUM_SRC(N), .ADDR_W(4), .STATUS_MASK(SMASK)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .cause_i(cause), .reg_addr_i(addr),
        .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    // behavioural reference model
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state <= '0;
            m_en    <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                bit clr_b, tst_b;
                clr_b = we && addr == 4'h0 && wdata[i];
                tst_b = we && addr == 4'h8 && wdata[i];
                if (SMASK[i]) m_state[i] <= cause[i] || tst_b;
                else          m_state[i] <= (m_state[i] && !clr_b) || cause[i] || tst_b;
            end
            if (we && addr == 4'h4) m_en <= wdata[N-1:0];
        end
    end

    always @(negedge clk) begin
        logic [31:0] exp_rd;
        logic [N-1:0] exp_irq;
        cycles++;
        exp_rd = '0;
        if (addr == 4'h0) exp_rd[N-1:0] = m_state;
        else if (addr == 4'h4) exp_rd[N-1:0] = m_en;
        exp_irq = m_state & m_en;
        checks += 2;
        if (rdata !== exp_rd) begin
            errors++;
            $display("FAIL %s rdata addr=%h actual=%h expected=%h", cur_req, addr, rdata, exp_rd);
        end
        if (irq !== exp_irq) begin
            errors++;
            $display("FAIL %s irq actual=%h expected=%h", cur_req, irq, exp_irq);
        end
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=5000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic cyc(input logic [N-1:0] c, input logic [3:0] a,
                       input logic w, input logic [31:0] d);
        @(posedge clk);
        #1;
        cause = c; addr = a; we = w; wdata = d;
    endtask

    initial begin
        // R1: reset state, reads of all offsets
        cur_req = "R1";
        cyc('0, 4'h0, 0, 0);
        cyc('0, 4'h4, 0, 0);
        cyc('0, 4'h8, 0, 0);
        rst_n = 1'b1;
        cyc('0, 4'h0, 0, 0);
        cyc('0, 4'h4, 0, 0);

        // R4 / R2: enable read/write at 0x4
        cur_req = "R4";
        cyc('0, 4'h4, 1, 32'h0000_00A5);
        cyc('0, 4'h4, 0, 0);
        cyc('0, 4'h4, 1, 32'h0000_005A);
        cyc('0, 4'h4, 0, 0);

        // R3: bits above NUM_SRC are masked
        cur_req = "R3";
        cyc('0, 4'h4, 1, 32'hFFFF_FF81);
        cyc('0, 4'h4, 0, 0);

        // R5: event sets and holds
        cur_req = "R5";
        cyc(8'h09, 4'h0, 0, 0);
        cyc('0, 4'h0, 0, 0);
        cyc('0, 4'h0, 0, 0);

        // R9: raw state vs masked output under a new enable
        cur_req = "R9";
        cyc('0, 4'h4, 1, 32'h0000_0008);
        cyc('0, 4'h0, 0, 0);
        cyc('0, 4'h4, 1, 32'h0000_00FF);
        cyc('0, 4'h0, 0, 0);

        // R6: write 0 ignored, write 1 clears
        cur_req = "R6";
        cyc('0, 4'h0, 1, 32'h0);
        cyc('0, 4'h0, 0, 0);
        cyc('0, 4'h0, 1, 32'h1);
        cyc('0, 4'h0, 0, 0);

        // R7: set wins over clear
        cur_req = "R7";
        cyc(8'h08, 4'h0, 1, 32'h08);
        cyc('0, 4'h0, 0, 0);
        cyc('0, 4'h0, 1, 32'h08);
        cyc('0, 4'h0, 0, 0);

        // R8: test sets state, reads zero, enable untouched
        cur_req = "R8";
        cyc('0, 4'h4, 1, 32'h0000_0001);
        cyc('0, 4'h8, 1, 32'h0000_0006);
        cyc('0, 4'h8, 0, 0);
        cyc('0, 4'h0, 0, 0);
        cyc('0, 4'h4, 0, 0);
        cyc('0, 4'h0, 1, 32'h06);
        cyc('0, 4'h0, 0, 0);

        // R10: status source follows its cause
        cur_req = "R10";
        cyc('0, 4'h4, 1, 32'h0000_00C0);
        cyc(8'h40, 4'h0, 0, 0);
        cyc(8'h40, 4'h0, 1, 32'h40);
        cyc(8'h40, 4'h0, 0, 0);
        cyc(8'h40, 4'h0, 0, 0);
        cyc('0, 4'h0, 0, 0);
        cyc('0, 4'h0, 0, 0);
        cyc('0, 4'h8, 1, 32'h80);
        cyc('0, 4'h0, 0, 0);
        cyc('0, 4'h0, 0, 0);

        // R11: unmapped offsets
        cur_req = "R11";
        cyc(8'h02, 4'h0, 0, 0);
        cyc('0, 4'hC, 1, 32'hFFFF_FFFF);
        cyc('0, 4'hC, 0, 0);
        cyc('0, 4'h1, 1, 32'hFFFF_FFFF);
        cyc('0, 4'h0, 0, 0);
        cyc('0, 4'h4, 0, 0);
        cyc('0, 4'h0, 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule